// File: doc/BRIEF.md
# Divider Configuration Port for a Clock Synthesizer

This block holds the configuration of a frequency synthesizer: a 9-bit feedback divide value, a 2-bit post-divide code and a 3-bit test-select code. Two sources can write these settings. The first is a set of parallel pins qualified by a parallel strobe. The second is a three-wire serial port made of a data line, a shift clock and a serial strobe. The current settings appear as registered outputs. The last stage of the serial shift register is also brought out so that the serial stream can be observed.

All pins are asynchronous to the block. They pass through a synchronizer on a fast system clock, and the capture latches are modelled as flip-flops on that clock. While the parallel strobe is low, the settings track the parallel pins and the test code is held at zero. While the parallel strobe is high and the serial strobe is high, the settings track the shift register. When neither strobe is active, the settings hold. A strobe edge that ends an active level therefore freezes the last value seen. Divide values are not range-checked.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset, `m_val` is 511 (all ones), `n_code` is 3, `t_sel` is 0 and `ser_tap` is 0. These match the idle pin levels: divide pins and parallel strobe high, serial pins low.
- R2: The shift register is 14 bits wide and shifts once per rising edge of `ser_clk`. `ser_tap` is its oldest stage, so a bit appears on `ser_tap` after 14 rising edges.
- R3: Field mapping of the 14-bit serial stream. The first three bits are the test code, sent most significant bit first. The next two bits are the post-divide code, most significant bit first. The last nine bits are the feedback value, bit 8 first.
- R4: While `par_ld` is high and `ser_ld` is high, the three outputs follow the shift register. When `ser_ld` falls, the value is kept, and later shifting does not change it.
- R5: While `par_ld` is low, `m_val` and `n_code` follow `par_m` and `par_n`. After `par_ld` rises, they keep the last value, and later pin changes have no effect.
- R6: While `par_ld` is low, `t_sel` is 0 and `ser_ld` has no effect on any output. The parallel path has priority.
- R7: While `par_ld` is high and `ser_ld` is low, shifting and pin changes leave all three outputs unchanged.
- R8: Any feedback value, including 0 and 511, is accepted from either path without range checking. The test code can take any of its 8 values through the serial path only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for sampling all pins |
| rst | input | 1 | Synchronous active-high reset |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel post-divide code |
| par_ld | input | 1 | Parallel strobe: low is transparent, rising edge captures |
| ser_dat | input | 1 | Serial data |
| ser_clk | input | 1 | Serial shift clock (rising edge shifts) |
| ser_ld | input | 1 | Serial strobe: high is transparent, falling edge captures |
| m_val | output | 9 | Current feedback divide value |
| n_code | output | 2 | Current post-divide code |
| t_sel | output | 3 | Current test-select code |
| ser_tap | output | 1 | Oldest shift register stage |

## Verification
Each pin passes two synchronizer flops. As a result, parallel values reach the outputs on the third clock edge after a pin change. A rising edge of `ser_clk` moves `ser_tap` on the third edge. Shift register contents reach the outputs through an open serial strobe one edge later, on the fourth edge. The bench changes pins just after a falling clock edge and then waits at least four full cycles before sampling on a falling edge, so every result is already due when it is read. Hold checks for R4, R5 and R7 disturb the inputs first, wait the same settle time, and then compare against the frozen expected value.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int DEF_M_W   = 9;
  localparam int DEF_N_W   = 2;
  localparam int DEF_T_W   = 3;
  localparam int DEF_SYNC  = 2;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cfg_shreg.sv
module cfg_shreg #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_s,
  input  logic         sdat_s,
  output logic [W-1:0] sr_q,
  output logic         tap
);
  logic sclk_d;
  logic rise;

  assign rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      sr_q   <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (rise) sr_q <= {sr_q[W-2:0], sdat_s};
    end
  end

  assign tap = sr_q[W-1];

  // R2
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(sr_q));
  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> (sr_q[W-1:1] == $past(sr_q[W-2:0])));
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3,
  localparam int SR_W = M_W + N_W + T_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pld_s,
  input  logic            sld_s,
  input  logic [M_W-1:0]  pm_s,
  input  logic [N_W-1:0]  pn_s,
  input  logic [SR_W-1:0] sr,
  output logic [M_W-1:0]  m_q,
  output logic [N_W-1:0]  n_q,
  output logic [T_W-1:0]  t_q
);
  logic [T_W-1:0] sr_t;
  logic [N_W-1:0] sr_n;
  logic [M_W-1:0] sr_m;

  // R3: oldest bits are the test code, then post-divide, then feedback
  assign sr_t = sr[SR_W-1 -: T_W];
  assign sr_n = sr[M_W +: N_W];
  assign sr_m = sr[M_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= '1;
      n_q <= '1;
      t_q <= '0;
    end else if (!pld_s) begin
      m_q <= pm_s;
      n_q <= pn_s;
      t_q <= '0;
    end else if (sld_s) begin
      m_q <= sr_m;
      n_q <= sr_n;
      t_q <= sr_t;
    end
  end

  // R6
  t_forced_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !pld_s |=> (t_q == '0));
  // R5
  par_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !pld_s |=> (m_q == $past(pm_s)) && (n_q == $past(pn_s)));
  // R4
  ser_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (pld_s && sld_s) |=> ({t_q, n_q, m_q} == $past(sr)));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pld_s && !sld_s) |=> ($stable(m_q) && $stable(n_q) && $stable(t_q)));
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import synth_cfg_pkg::*;
#(
  parameter int M_W   = DEF_M_W,
  parameter int N_W   = DEF_N_W,
  parameter int T_W   = DEF_T_W,
  parameter int SYNC  = DEF_SYNC
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           par_ld,
  input  logic           ser_dat,
  input  logic           ser_clk,
  input  logic           ser_ld,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_code,
  output logic [T_W-1:0] t_sel,
  output logic           ser_tap
);
  localparam int SR_W = M_W + N_W + T_W;
  localparam int IN_W = M_W + N_W + 4;
  localparam logic [IN_W-1:0] IDLE = {1'b1, 3'b000, {N_W{1'b1}}, {M_W{1'b1}}};

  logic [IN_W-1:0] pins_s;
  logic [SR_W-1:0] sr;
  logic            pld_s, sld_s, sclk_s, sdat_s;
  logic [N_W-1:0]  pn_s;
  logic [M_W-1:0]  pm_s;

  cfg_sync #(.W(IN_W), .STAGES(SYNC), .RST_VAL(IDLE)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({par_ld, ser_ld, ser_clk, ser_dat, par_n, par_m}),
    .q   (pins_s)
  );

  assign {pld_s, sld_s, sclk_s, sdat_s, pn_s, pm_s} = pins_s;

  cfg_shreg #(.W(SR_W)) shreg_i (
    .clk    (clk),
    .rst    (rst),
    .sclk_s (sclk_s),
    .sdat_s (sdat_s),
    .sr_q   (sr),
    .tap    (ser_tap)
  );

  cfg_hold #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) hold_i (
    .clk   (clk),
    .rst   (rst),
    .pld_s (pld_s),
    .sld_s (sld_s),
    .pm_s  (pm_s),
    .pn_s  (pn_s),
    .sr    (sr),
    .m_q   (m_val),
    .n_q   (n_code),
    .t_q   (t_sel)
  );

  // R1
  reset_val_chk: assert property (@(posedge clk)
    rst |=> (m_val == '1) && (n_code == '1) && (t_sel == '0) && !ser_tap);
endmodule

// File: tb/synth_cfg_port_tb_top.sv
module synth_cfg_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] par_m = 9'h1FF;
  logic [1:0] par_n = 2'b11;
  logic       par_ld = 1'b1;
  logic       ser_dat = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_ld = 1'b0;
  logic [8:0] m_val;
  logic [1:0] n_code;
  logic [2:0] t_sel;
  logic       ser_tap;

  int checks = 0;
  int errors = 0;
  logic [13:0] mdl_sr = '0;
  logic [8:0]  exp_m = 9'h1FF;
  logic [1:0]  exp_n = 2'b11;
  logic [2:0]  exp_t = 3'b000;

  always #4 clk = ~clk;

  synth_cfg_port dut_i (
    .clk(clk), .rst(rst), .par_m(par_m), .par_n(par_n), .par_ld(par_ld),
    .ser_dat(ser_dat), .ser_clk(ser_clk), .ser_ld(ser_ld),
    .m_val(m_val), .n_code(n_code), .t_sel(t_sel), .ser_tap(ser_tap)
  );

  function automatic logic [13:0] pack_word(logic [2:0] t, logic [1:0] n, logic [8:0] m);
    return {t, n, m};
  endfunction

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check({req, " m"}, int'(m_val), int'(exp_m));
    check({req, " n"}, int'(n_code), int'(exp_n));
    check({req, " t"}, int'(t_sel), int'(exp_t));
  endtask

  task automatic ser_bit(logic b);
    ser_dat = b;
    wait_clks(4);
    ser_clk = 1'b1;
    mdl_sr = {mdl_sr[12:0], b};
    wait_clks(4);
    check("R2 tap", int'(ser_tap), int'(mdl_sr[13]));
    ser_clk = 1'b0;
    wait_clks(4);
  endtask

  task automatic ser_word(logic [13:0] w);
    for (int i = 13; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic ser_pulse();
    ser_ld = 1'b1;
    wait_clks(6);
    if (par_ld) begin
      exp_t = mdl_sr[13:11];
      exp_n = mdl_sr[10:9];
      exp_m = mdl_sr[8:0];
    end
    check_all("R4 open");
    ser_ld = 1'b0;
    wait_clks(6);
  endtask

  task automatic par_load(logic [8:0] m, logic [1:0] n);
    par_m = m;
    par_n = n;
    par_ld = 1'b0;
    wait_clks(6);
    exp_m = m; exp_n = n; exp_t = 3'b000;
    check_all("R5 R6 open");
    par_ld = 1'b1;
    wait_clks(6);
    par_m = ~m;
    par_n = ~n;
    wait_clks(6);
    check_all("R5 hold");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    wait_clks(3);
    rst = 1'b0;
    wait_clks(1);
    // R1 reset state
    check_all("R1");
    check("R1 tap", int'(ser_tap), 0);

    // R3 directed field mapping, R2 first-bit arrival on the tap
    ser_word(pack_word(3'b101, 2'b01, 9'h106));
    ser_pulse();
    check("R3 t", int'(t_sel), 5);
    check("R3 n", int'(n_code), 1);
    check("R3 m", int'(m_val), 262);

    // R4 capture kept after falling strobe despite new shifting
    ser_word(pack_word(3'b010, 2'b10, 9'h0AA));
    wait_clks(4);
    check_all("R4 kept");

    // R5 parallel load and hold
    par_load(9'h0C8, 2'b00);

    // R6 serial strobe ignored while parallel strobe low
    par_m = 9'h155; par_n = 2'b10; par_ld = 1'b0;
    wait_clks(6);
    exp_m = 9'h155; exp_n = 2'b10; exp_t = 3'b000;
    ser_word(pack_word(3'b111, 2'b01, 9'h033));
    ser_pulse();
    check_all("R6 priority");
    par_ld = 1'b1;
    wait_clks(6);
    check_all("R6 release");

    // R7 idle: shifting and pin changes have no effect
    par_m = 9'h001; par_n = 2'b01;
    ser_word(pack_word(3'b110, 2'b11, 9'h1F0));
    wait_clks(6);
    check_all("R7 idle");

    // R8 extreme feedback values, all test codes
    par_load(9'h000, 2'b11);
    check("R8 m zero", int'(m_val), 0);
    ser_word(pack_word(3'b111, 2'b00, 9'h1FF));
    ser_pulse();
    check("R8 m max", int'(m_val), 511);
    check("R8 t max", int'(t_sel), 7);

    // random mix
    for (int k = 0; k < 20; k++) begin
      logic [8:0] rm;
      logic [1:0] rn;
      logic [2:0] rt;
      rm = 9'($urandom);
      rn = 2'($urandom);
      rt = 3'($urandom);
      if ($urandom % 2 == 0) begin
        par_load(rm, rn);
      end else begin
        ser_word(pack_word(rt, rn, rm));
        ser_pulse();
        check("R3 rand t", int'(t_sel), int'(rt));
        check("R3 rand m", int'(m_val), int'(rm));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule